// File: doc/BRIEF.md
# Command-Response Serial Slave (Three-Wire, Half-Duplex)

This block is the target end of a half-duplex three-wire serial link. While its select input is held low, a master clocks in an 8-bit command, most significant bit first, on rising serial clock edges. The block spends exactly one serial clock period on decoding. During that gap it fetches a reply word from a synchronous lookup port, indexed by the command. It then shifts the reply out, MSB first, on the falling edges. The reply length is a build-time parameter between 4 and 32 bits, so a frame lasts 8 + 1 + RESP_BITS serial clocks.

All three serial inputs are oversampled by the system clock. They pass through a synchronizer chain, and clock edges are detected in the system clock domain. The system clock must run at least 8 times faster than the serial clock. The data output comes with an enable for a tri-state pad. The enable is high only while a reply is being driven.

The select input may stay low after a reply. The next eight rising edges then form a new command. Raising select at any point aborts the frame.

The lookup request is a valid/ready stream:
- The block raises `req_valid_o` with the command on `req_cmd_o`.
- It holds both stable until `req_ready_i` is seen high.
- If the request has not been accepted when the first reply bit must be driven, it is withdrawn.

The reply side has no back-pressure. A `rsp_valid_i` pulse is taken whenever a reply is outstanding. If no reply has arrived by the first falling edge of the response phase, an all-zero word is sent.

Top module: `mw_cmd_slave`

## Requirements
- R1: After reset, and while select is high, `sdo_oe_o` is 0, `sdo_o` is 0 and `req_valid_o` is 0.
- R2: Command bits are captured MSB first on rising serial clock edges while select is low. The first bit is the first rising edge after select falls. Rising edges while select is high are ignored.
- R3: After the 8th command bit, exactly one request is raised with `req_cmd_o` equal to the captured byte. Valid and command stay stable until `req_ready_i` is high, or until the first reply bit is driven.
- R4: The reply word is the `rsp_data_i` value accepted after the request. If none has arrived before the response starts, the reply is all zeros.
- R5: After the 8th command bit, the falling edge and the 9th rising edge form the decode gap, during which `sdo_oe_o` stays 0. The reply MSB is driven on the next falling edge, and `sdo_oe_o` rises with it.
- R6: The reply is RESP_BITS long and is shifted MSB first, one bit per falling edge. The master reads bit k of the reply (counted from the MSB, k = 0 for the MSB) on rising edge 10+k of the frame.
- R7: `sdo_oe_o` is 0 throughout the command phase. It drops on the falling edge that follows the rising edge on which the LSB is read.
- R8: If select stays low after the LSB, the next eight rising edges form a new command, handled exactly like the first.
- R9: Select going high mid-frame ends the frame. The block returns to idle with `sdo_oe_o` at 0 within the synchronizer delay, and its bit counts are cleared, so the next frame starts from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master, idle low |
| cs_n_i | input | 1 | Active-low select from the master |
| sdi_i | input | 1 | Serial command data in |
| sdo_o | output | 1 | Serial reply data out (0 when not enabled) |
| sdo_oe_o | output | 1 | Output enable for the tri-state data pad |
| req_valid_o | output | 1 | Lookup request valid |
| req_ready_i | input | 1 | Lookup request accepted |
| req_cmd_o | output | 8 | Command byte used as the lookup index |
| rsp_valid_i | input | 1 | Lookup reply valid (single-cycle pulse) |
| rsp_data_i | input | RESP_BITS | Lookup reply word |

## Verification
The bench builds the block with RESP_BITS = 16 and two synchronizer stages. Its serial clock period is 16 system clocks. This makes 25-clock frames long enough to check the decode gap, the release edge and chained commands, while every bit of the reply still has a visible value. Because the serial clock ratio is 16, the bench can hold the request stalled past the end of the command and still deliver the reply inside the gap. It also contrasts this with a lookup that never replies, and so reaches both branches of the reply capture.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_GAP  = 2'd2,
    ST_RESP = 2'd3
  } mw_state_e;

  localparam int unsigned CMD_BITS = 8;
  localparam int unsigned IO_SCLK  = 0;
  localparam int unsigned IO_CSN   = 1;
  localparam int unsigned IO_SDI   = 2;
  localparam int unsigned IO_W     = 3;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] pipe;
  logic [W-1:0] q_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) pipe[i] <= RST_VAL;
      q_d <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
      q_d <= pipe[STAGES-1];
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = q & ~q_d;
  assign fall = ~q & q_d;
endmodule

// File: rtl/mw_cmd_rx.sv
module mw_cmd_rx #(
  parameter int unsigned CMD_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                shift,
  input  logic                bit_in,
  output logic [CMD_BITS-1:0] word_next,
  output logic                last
);
  localparam int unsigned CW = $clog2(CMD_BITS + 1);

  logic [CW-1:0]       cnt;
  logic [CMD_BITS-1:0] word;

  assign word_next = {word[CMD_BITS-2:0], bit_in};
  assign last      = shift && (cnt == CW'(CMD_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      word <= '0;
    end else if (clr) begin
      cnt  <= '0;
      word <= '0;
    end else if (shift) begin
      cnt  <= cnt + CW'(1);
      word <= word_next;
    end
  end
endmodule

// File: rtl/mw_resp_tx.sv
module mw_resp_tx #(
  parameter int unsigned RESP_BITS = 16,
  localparam int unsigned CW = $clog2(RESP_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 load,
  input  logic [RESP_BITS-1:0] load_data,
  input  logic                 shift,
  output logic                 bit_out,
  output logic                 started,
  output logic                 done,
  output logic [CW-1:0]        count
);
  logic [RESP_BITS-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      count <= '0;
    end else if (clr) begin
      sreg  <= '0;
      count <= '0;
    end else if (load) begin
      sreg  <= load_data;
      count <= CW'(1);
    end else if (shift) begin
      sreg  <= {sreg[RESP_BITS-2:0], 1'b0};
      count <= count + CW'(1);
    end
  end

  assign bit_out = sreg[RESP_BITS-1];
  assign started = (count != '0);
  assign done    = (count == CW'(RESP_BITS));
endmodule

// File: rtl/mw_lookup_port.sv
module mw_lookup_port #(
  parameter int unsigned CMD_BITS  = 8,
  parameter int unsigned RESP_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 abort,
  input  logic                 issue,
  input  logic [CMD_BITS-1:0]  issue_cmd,
  input  logic                 consume,
  input  logic                 req_ready_i,
  input  logic                 rsp_valid_i,
  input  logic [RESP_BITS-1:0] rsp_data_i,
  output logic                 req_valid_o,
  output logic [CMD_BITS-1:0]  req_cmd_o,
  output logic [RESP_BITS-1:0] reply
);
  logic                 pending;
  logic                 have;
  logic [RESP_BITS-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid_o <= 1'b0;
      req_cmd_o   <= '0;
      pending     <= 1'b0;
      have        <= 1'b0;
      word        <= '0;
    end else if (abort || consume) begin
      req_valid_o <= 1'b0;
      pending     <= 1'b0;
      have        <= 1'b0;
      word        <= '0;
    end else if (issue) begin
      req_valid_o <= 1'b1;
      req_cmd_o   <= issue_cmd;
      pending     <= 1'b1;
      have        <= 1'b0;
      word        <= '0;
    end else begin
      if (req_valid_o && req_ready_i) req_valid_o <= 1'b0;
      if (pending && rsp_valid_i) begin
        word    <= rsp_data_i;
        have    <= 1'b1;
        pending <= 1'b0;
      end
    end
  end

  assign reply = have ? word : '0;
endmodule

// File: rtl/mw_cmd_slave.sv
module mw_cmd_slave
  import mw_pkg::*;
#(
  parameter int unsigned RESP_BITS   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_i,
  input  logic                 cs_n_i,
  input  logic                 sdi_i,
  output logic                 sdo_o,
  output logic                 sdo_oe_o,
  output logic                 req_valid_o,
  input  logic                 req_ready_i,
  output logic [CMD_BITS-1:0]  req_cmd_o,
  input  logic                 rsp_valid_i,
  input  logic [RESP_BITS-1:0] rsp_data_i
);
  localparam int unsigned TXW = $clog2(RESP_BITS + 1);
  localparam logic [IO_W-1:0] IO_RST = IO_W'(1) << IO_CSN;

  mw_state_e state;
  logic      oe_q;

  logic [IO_W-1:0] io_q, io_rise, io_fall;
  logic sclk_rise, sclk_fall, cs_hi, sdi_s;

  mw_sync #(.W(IO_W), .STAGES(SYNC_STAGES), .RST_VAL(IO_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sdi_i, cs_n_i, sclk_i}),
    .q    (io_q),
    .rise (io_rise),
    .fall (io_fall)
  );

  assign sclk_rise = io_rise[IO_SCLK];
  assign sclk_fall = io_fall[IO_SCLK];
  assign cs_hi     = io_q[IO_CSN];
  assign sdi_s     = io_q[IO_SDI];

  logic                cmd_shift, cmd_clr, cmd_last;
  logic [CMD_BITS-1:0] cmd_next;

  assign cmd_shift = (state == ST_CMD) && !cs_hi && sclk_rise;
  assign cmd_clr   = (state != ST_CMD) || cs_hi;

  mw_cmd_rx #(.CMD_BITS(CMD_BITS)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cmd_clr),
    .shift    (cmd_shift),
    .bit_in   (sdi_s),
    .word_next(cmd_next),
    .last     (cmd_last)
  );

  logic           tx_clr, tx_load, tx_shift, tx_bit, tx_started, tx_done;
  logic [TXW-1:0] tx_cnt;
  logic [RESP_BITS-1:0] reply;

  assign tx_clr   = (state != ST_RESP) || cs_hi;
  assign tx_load  = (state == ST_RESP) && !cs_hi && sclk_fall && !tx_started;
  assign tx_shift = (state == ST_RESP) && !cs_hi && sclk_fall && tx_started && !tx_done;

  mw_resp_tx #(.RESP_BITS(RESP_BITS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tx_clr),
    .load     (tx_load),
    .load_data(reply),
    .shift    (tx_shift),
    .bit_out  (tx_bit),
    .started  (tx_started),
    .done     (tx_done),
    .count    (tx_cnt)
  );

  mw_lookup_port #(.CMD_BITS(CMD_BITS), .RESP_BITS(RESP_BITS)) u_lookup (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (cs_hi),
    .issue      (cmd_last),
    .issue_cmd  (cmd_next),
    .consume    (tx_load),
    .req_ready_i(req_ready_i),
    .rsp_valid_i(rsp_valid_i),
    .rsp_data_i (rsp_data_i),
    .req_valid_o(req_valid_o),
    .req_cmd_o  (req_cmd_o),
    .reply      (reply)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else if (cs_hi) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_CMD;
        ST_CMD: begin
          if (sclk_fall) oe_q <= 1'b0;
          if (cmd_last) state <= ST_GAP;
        end
        ST_GAP: begin
          if (sclk_rise) state <= ST_RESP;
        end
        ST_RESP: begin
          if (tx_load) oe_q <= 1'b1;
          if (sclk_rise && tx_done) state <= ST_CMD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdo_oe_o = oe_q;
  assign sdo_o    = oe_q & tx_bit;
endmodule

// File: rtl/mw_cmd_slave_chk.sv
module mw_cmd_slave_chk
  import mw_pkg::*;
#(
  parameter int unsigned RESP_BITS = 16,
  localparam int unsigned TXW = $clog2(RESP_BITS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_hi,
  input logic                sclk_fall,
  input logic                tx_load,
  input mw_state_e           state,
  input logic [TXW-1:0]      tx_cnt,
  input logic                sdo_oe_o,
  input logic                req_valid_o,
  input logic                req_ready_i,
  input logic [CMD_BITS-1:0] req_cmd_o
);
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (!sdo_oe_o && state == ST_IDLE));

  a_r5_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> !sdo_oe_o);

  a_r6_oe_starts_msb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> (state == ST_RESP && tx_cnt == TXW'(1)));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TXW'(RESP_BITS));

  a_r7_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe_o) |-> ($past(sclk_fall) || $past(cs_hi)));

  a_r3_req_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid_o) |-> (state == ST_GAP));

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i && !cs_hi && !tx_load) |=>
      (req_valid_o && $stable(req_cmd_o)));
endmodule

bind mw_cmd_slave mw_cmd_slave_chk #(.RESP_BITS(RESP_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_hi      (cs_hi),
  .sclk_fall  (sclk_fall),
  .tx_load    (tx_load),
  .state      (state),
  .tx_cnt     (tx_cnt),
  .sdo_oe_o   (sdo_oe_o),
  .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i),
  .req_cmd_o  (req_cmd_o)
);

// File: tb/mw_cmd_slave_bench.sv
module mw_cmd_slave_bench;
  localparam int RB   = 16;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic req_ready = 1'b1, rsp_valid = 1'b0;
  logic [RB-1:0] rsp_data = '0;
  logic sdo, oe, req_valid;
  logic [7:0] req_cmd;

  int n_chk = 0, n_fail = 0, req_seen = 0;
  bit lk_mute = 1'b0;

  always #10 clk = ~clk;

  mw_cmd_slave #(.RESP_BITS(RB), .SYNC_STAGES(2)) u_mw_cmd_slave (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(oe), .req_valid_o(req_valid), .req_ready_i(req_ready),
    .req_cmd_o(req_cmd), .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data)
  );

  function automatic logic [RB-1:0] reply_of(input logic [7:0] c);
    logic [31:0] w;
    w = {c, ~c, c ^ 8'h5A, 8'hC3};
    return w[31 -: RB];
  endfunction

  // lookup model: accepts when ready, replies one cycle later
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (req_valid && req_ready) begin
      req_seen  <= req_seen + 1;
      rsp_valid <= !lk_mute;
      rsp_data  <= reply_of(req_cmd);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic s, output logic o);
    sdi = b;
    wait_clk(HALF);
    sclk = 1'b1;
    s = sdo;
    o = oe;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c, output int oe_hits);
    logic s, o;
    oe_hits = 0;
    for (int i = 7; i >= 0; i--) begin
      sbit(c[i], s, o);
      oe_hits += int'(o);
    end
  endtask

  task automatic recv(input int n, output logic [RB-1:0] got, output int oe_ones);
    logic s, o;
    got = '0;
    oe_ones = 0;
    for (int i = 0; i < n; i++) begin
      sbit(1'b0, s, o);
      got = {got[RB-2:0], s};
      oe_ones += int'(o);
    end
  endtask

  task automatic do_frame(input logic [7:0] c, input bit last, input logic [RB-1:0] exp,
                          input string tag);
    int hits, ones;
    logic s, o;
    logic [RB-1:0] got;
    cs_n = 1'b0;
    send_cmd(c, hits);
    chk({tag, " R7 oe low in command"}, hits, 0);
    sbit(1'b0, s, o);
    chk({tag, " R5 oe low in gap"}, o, 0);
    recv(RB, got, ones);
    chk({tag, " R6 reply word"}, got, exp);
    chk({tag, " R5 oe high over reply"}, ones, RB);
    if (last) begin
      wait_clk(HALF - 2);
      chk({tag, " R7 release after LSB"}, oe, 0);
      cs_n = 1'b1;
      wait_clk(2 * HALF);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset oe", oe, 0);
    chk("R1 reset sdo", sdo, 0);
    chk("R1 reset req_valid", req_valid, 0);
  endtask

  task automatic t_single;
    int seen0;
    seen0 = req_seen;
    do_frame(8'hA5, 1'b1, reply_of(8'hA5), "single A5");
    chk("R3 one request per frame", req_seen - seen0, 1);
    do_frame(8'h3C, 1'b1, reply_of(8'h3C), "single 3C R2");
  endtask

  task automatic t_back2back;
    do_frame(8'h81, 1'b0, reply_of(8'h81), "chain 1 R8");
    do_frame(8'h7E, 1'b0, reply_of(8'h7E), "chain 2 R8");
    do_frame(8'hC3, 1'b1, reply_of(8'hC3), "chain 3 R8");
  endtask

  task automatic t_idle_clocks;
    int seen0;
    logic s, o;
    seen0 = req_seen;
    for (int i = 0; i < 10; i++) sbit(i[0], s, o);
    wait_clk(4);
    chk("R2 clocks ignored while deselected", req_seen - seen0, 0);
    chk("R1 oe low while deselected", oe, 0);
    do_frame(8'h5A, 1'b1, reply_of(8'h5A), "after idle clocks R2");
  endtask

  task automatic t_abort_cmd;
    logic s, o;
    cs_n = 1'b0;
    for (int i = 0; i < 4; i++) sbit(1'b1, s, o);
    cs_n = 1'b1;
    wait_clk(6);
    chk("R9 abort in command oe", oe, 0);
    chk("R9 abort in command no request", req_valid, 0);
    wait_clk(2 * HALF);
    do_frame(8'hE1, 1'b1, reply_of(8'hE1), "after command abort R9");
  endtask

  task automatic t_abort_resp;
    int hits, ones;
    logic s, o;
    logic [RB-1:0] got;
    cs_n = 1'b0;
    send_cmd(8'h96, hits);
    sbit(1'b0, s, o);
    recv(5, got, ones);
    chk("R9 driving before abort", ones, 5);
    cs_n = 1'b1;
    wait_clk(5);
    chk("R9 abort in reply oe", oe, 0);
    wait_clk(2 * HALF);
    do_frame(8'h69, 1'b1, reply_of(8'h69), "after reply abort R9");
  endtask

  task automatic t_stall;
    int hits, ones;
    logic s, o;
    logic [RB-1:0] got;
    req_ready = 1'b0;
    cs_n = 1'b0;
    send_cmd(8'h4B, hits);
    chk("R3 request raised", req_valid, 1);
    chk("R3 request command", req_cmd, 8'h4B);
    wait_clk(2);
    chk("R3 request held under stall", req_valid, 1);
    chk("R3 command stable under stall", req_cmd, 8'h4B);
    req_ready = 1'b1;
    sbit(1'b0, s, o);
    recv(RB, got, ones);
    chk("R4 late accepted reply", got, reply_of(8'h4B));
    wait_clk(HALF - 2);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic t_mute;
    lk_mute = 1'b1;
    do_frame(8'h2D, 1'b1, '0, "no reply R4");
    lk_mute = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_single();
    t_back2back();
    t_idle_clocks();
    t_abort_cmd();
    t_abort_resp();
    t_stall();
    t_mute();
    finish_run();
  end
endmodule